// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Saturating Accumulators

This block is a single-cycle multiply-accumulate datapath for a signal-processing core. Each accepted operation takes two 16-bit operands. Each operand is widened to 17 bits, either sign-extended or zero-extended as its own sign control says, so signed, unsigned and mixed-sign products all come out of one 17x17 multiplier. In fractional mode the product is doubled. The result then clears one of two 40-bit accumulators, loads it, adds to it or subtracts from it. The accumulator chosen by the select input takes the new value on the same clock edge. Saturation is optional and is chosen per operation.

The accumulators carry eight guard bits above a 32-bit working range. When saturation is enabled, any result that leaves the signed 32-bit range is clamped to its nearest bound. Each accumulator also has a sticky flag that records a loss of the true result beyond its 40-bit width.

The operation input is a valid/ready stream. `in_ready` is held high, so the block never applies back-pressure: every cycle with `in_valid` high is one accepted operation. Cycles with `in_valid` low have no effect.

Top module: `frac_mac`

## Requirements
- R1: While `rst_n` is low, both accumulators reset to zero and both overflow flags reset to zero.
- R2: Each operand is extended to 17 bits. Extension is by sign when its sign control (`a_signed`, `b_signed`) is 1 and by zero when it is 0. The product is the exact 34-bit signed product of the extended values, for all four sign combinations.
- R3: When `frac_en` is 1, the product is shifted left by one bit before it reaches the accumulator. When `frac_en` is 0 it is used unshifted.
- R4: With `frac_en` = 1, both operands signed and saturation off, 0x8000 times 0x8000 gives exactly 0x0080000000, which is +1.0 in the working format.
- R5: `op` = 2 (multiply-add) writes accumulator + product into the selected accumulator. The new value is visible on the output after the accepting clock edge.
- R6: `op` = 3 (multiply-subtract) writes accumulator − product into the selected accumulator.
- R7: `op` = 1 (load) replaces the selected accumulator with the product.
- R8: `op` = 0 (clear) sets the selected accumulator and its overflow flag to zero.
- R9: When `sat_en` is 1 and the true result of a load, add or subtract is above 2^31−1 or below −2^31, the accumulator takes 0x007FFFFFFF or 0xFF80000000 respectively.
- R10: When `sat_en` is 0, the accumulator takes the true result modulo 2^40. The flag `ovf[k]` for accumulator k (bit 0 is accumulator 0) is set whenever a true result falls outside the signed 40-bit range. It stays set until a clear of that accumulator.
- R11: A cycle with `in_valid` low changes neither accumulator nor either flag. An accepted operation changes only the accumulator and flag named by `acc_sel`.
- R12: `in_ready` is 1 in every cycle, so no operation is ever stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered this cycle |
| in_ready | output | 1 | Always 1; the block never stalls |
| op_a | input | 16 | First multiplier operand |
| op_b | input | 16 | Second multiplier operand |
| a_signed | input | 1 | 1: op_a is two's complement; 0: unsigned |
| b_signed | input | 1 | 1: op_b is two's complement; 0: unsigned |
| acc_sel | input | 1 | Target accumulator (0 or 1) |
| op | input | 2 | 0 clear, 1 load, 2 multiply-add, 3 multiply-subtract |
| frac_en | input | 1 | Double the product (fractional format) |
| sat_en | input | 1 | Clamp the result to the signed 32-bit range |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| ovf | output | 2 | Sticky 40-bit overflow flags, bit k for accumulator k |

## Verification
Every accepted operation shows its result on `acc0`, `acc1` and `ovf` exactly one clock edge after it is accepted, because the accumulator register is the only state on the path. The bench drives each operation on a falling edge, lets one rising edge pass, and compares all three outputs with its arithmetic model on the next falling edge. It then drives the following operation at that same falling edge, so checks run back to back with no slack. Idle cycles are checked the same way, one edge after the operation is withheld.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  typedef enum logic [1:0] {
    OP_CLR  = 2'd0,
    OP_LOAD = 2'd1,
    OP_MAC  = 2'd2,
    OP_MSC  = 2'd3
  } mac_op_e;
endpackage

// File: rtl/frac_mac_mult.sv
// Operand widening, 17x17 signed multiply and optional fractional doubling (R2, R3).
module frac_mac_mult #(
  parameter int OP_W   = 16,
  parameter int PROD_W = 2 * (OP_W + 1) + 1
) (
  input  logic [OP_W-1:0]          a,
  input  logic [OP_W-1:0]          b,
  input  logic                     a_sgn,
  input  logic                     b_sgn,
  input  logic                     frac,
  output logic signed [PROD_W-1:0] prod
);
  localparam int EXT_W = OP_W + 1;
  localparam int RAW_W = 2 * EXT_W;

  logic signed [EXT_W-1:0] a_ext;
  logic signed [EXT_W-1:0] b_ext;
  logic signed [RAW_W-1:0] raw;

  always_comb begin
    a_ext = {a_sgn & a[OP_W-1], a};
    b_ext = {b_sgn & b[OP_W-1], b};
    raw   = a_ext * b_ext;
    if (frac) prod = {raw, 1'b0};
    else      prod = {raw[RAW_W-1], raw};
  end
endmodule

// File: rtl/frac_mac_addsat.sv
// Add/subtract against the selected accumulator, overflow detect and clamp (R5-R10).
module frac_mac_addsat
  import frac_mac_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int PROD_W  = 35,
  parameter int SAT_BIT = 31
) (
  input  logic [ACC_W-1:0]         acc,
  input  logic signed [PROD_W-1:0] prod,
  input  mac_op_e                  op,
  input  logic                     sat,
  output logic [ACC_W-1:0]         result,
  output logic                     wide_ovf
);
  localparam int SUM_W = ACC_W + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI = {{(SUM_W - SAT_BIT){1'b0}}, {SAT_BIT{1'b1}}};
  localparam logic signed [SUM_W-1:0] SAT_LO = {{(SUM_W - SAT_BIT){1'b1}}, {SAT_BIT{1'b0}}};

  logic signed [SUM_W-1:0] base;
  logic signed [SUM_W-1:0] addend;
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    base   = (op == OP_LOAD) ? '0 : {acc[ACC_W-1], acc};
    addend = {{(SUM_W - PROD_W){prod[PROD_W-1]}}, prod};
    sum    = (op == OP_MSC) ? (base - addend) : (base + addend);
    // True result lost beyond ACC_W bits when the two top bits disagree.
    wide_ovf = sum[SUM_W-1] ^ sum[SUM_W-2];
    if (sat && (sum > SAT_HI))      result = SAT_HI[ACC_W-1:0];
    else if (sat && (sum < SAT_LO)) result = SAT_LO[ACC_W-1:0];
    else                            result = sum[ACC_W-1:0];
  end
endmodule

// File: rtl/frac_mac_bank.sv
// Accumulator registers and sticky overflow flags (R1, R8, R10, R11).
module frac_mac_bank #(
  parameter int N_ACC = 2,
  parameter int ACC_W = 40,
  parameter int SEL_W = (N_ACC > 1) ? $clog2(N_ACC) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        clr,
  input  logic [SEL_W-1:0]            sel,
  input  logic [ACC_W-1:0]            wr_data,
  input  logic                        wr_ovf,
  output logic [N_ACC-1:0][ACC_W-1:0] acc_q,
  output logic [N_ACC-1:0]            ovf_q
);
  for (genvar k = 0; k < N_ACC; k++) begin : g_acc
    logic hit;
    assign hit = wr_en && (sel == SEL_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[k] <= '0;
        ovf_q[k] <= 1'b0;
      end else if (hit) begin
        if (clr) begin
          acc_q[k] <= '0;
          ovf_q[k] <= 1'b0;
        end else begin
          acc_q[k] <= wr_data;
          ovf_q[k] <= ovf_q[k] | wr_ovf;
        end
      end
    end
  end
endmodule

// File: rtl/frac_mac.sv
module frac_mac
  import frac_mac_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int ACC_W   = 40,
  parameter int SAT_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic             a_signed,
  input  logic             b_signed,
  input  logic             acc_sel,
  input  logic [1:0]       op,
  input  logic             frac_en,
  input  logic             sat_en,
  output logic [ACC_W-1:0] acc0,
  output logic [ACC_W-1:0] acc1,
  output logic [1:0]       ovf
);
  localparam int N_ACC  = 2;
  localparam int PROD_W = 2 * (OP_W + 1) + 1;

  mac_op_e                     op_e;
  logic signed [PROD_W-1:0]    prod;
  logic [ACC_W-1:0]            acc_cur;
  logic [ACC_W-1:0]            next_val;
  logic                        next_ovf;
  logic [N_ACC-1:0][ACC_W-1:0] acc_q;
  logic [N_ACC-1:0]            ovf_q;

  assign op_e     = mac_op_e'(op);
  assign in_ready = 1'b1;
  assign acc_cur  = acc_q[acc_sel];

  frac_mac_mult #(.OP_W(OP_W), .PROD_W(PROD_W)) u_mult (
    .a(op_a), .b(op_b), .a_sgn(a_signed), .b_sgn(b_signed),
    .frac(frac_en), .prod(prod)
  );

  frac_mac_addsat #(.ACC_W(ACC_W), .PROD_W(PROD_W), .SAT_BIT(SAT_BIT)) u_addsat (
    .acc(acc_cur), .prod(prod), .op(op_e), .sat(sat_en),
    .result(next_val), .wide_ovf(next_ovf)
  );

  frac_mac_bank #(.N_ACC(N_ACC), .ACC_W(ACC_W), .SEL_W(1)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .clr(op_e == OP_CLR),
    .sel(acc_sel), .wr_data(next_val), .wr_ovf(next_ovf),
    .acc_q(acc_q), .ovf_q(ovf_q)
  );

  assign acc0 = acc_q[0];
  assign acc1 = acc_q[1];
  assign ovf  = ovf_q;
endmodule

// File: rtl/frac_mac_chk.sv
module frac_mac_chk #(
  parameter int ACC_W   = 40,
  parameter int SAT_BIT = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             acc_sel,
  input logic [1:0]       op,
  input logic             sat_en,
  input logic [ACC_W-1:0] acc0,
  input logic [ACC_W-1:0] acc1,
  input logic [1:0]       ovf
);
  localparam logic signed [ACC_W-1:0] HI = {{(ACC_W - SAT_BIT){1'b0}}, {SAT_BIT{1'b1}}};
  localparam logic signed [ACC_W-1:0] LO = {{(ACC_W - SAT_BIT){1'b1}}, {SAT_BIT{1'b0}}};

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc0) && $stable(acc1) && $stable(ovf)));

  a_r11_sel0_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !acc_sel) |=> ($stable(acc1) && $stable(ovf[1])));

  a_r11_sel1_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_sel) |=> ($stable(acc0) && $stable(ovf[0])));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !acc_sel && op == 2'd0) |=> (acc0 == '0 && !ovf[0]));

  a_r9_sat_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !acc_sel && sat_en && op != 2'd0)
      |=> ($signed(acc0) <= HI && $signed(acc0) >= LO));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[0] && !(in_valid && !acc_sel && op == 2'd0)) |=> ovf[0]);
endmodule

bind frac_mac frac_mac_chk #(.ACC_W(ACC_W), .SAT_BIT(SAT_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_sel(acc_sel), .op(op),
  .sat_en(sat_en), .acc0(acc0), .acc1(acc1), .ovf(ovf)
);

// File: tb/frac_mac_tb.sv
`timescale 1ns/1ps
module frac_mac_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] op_a = '0, op_b = '0;
  logic        a_signed = 1'b0, b_signed = 1'b0, acc_sel = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        frac_en = 1'b0, sat_en = 1'b0;
  logic [39:0] acc0, acc1;
  logic [1:0]  ovf;

  int     n_vec = 0;
  int     n_bad = 0;
  longint m_acc [2];
  logic   m_ovf [2];
  bit     done = 1'b0;

  localparam longint ACC_MAX = (64'sd1 <<< 39) - 1;
  localparam longint ACC_MIN = -(64'sd1 <<< 39);
  localparam longint SAT_HI  = (64'sd1 <<< 31) - 1;
  localparam longint SAT_LO  = -(64'sd1 <<< 31);

  always #2 clk = ~clk;

  frac_mac u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .a_signed(a_signed), .b_signed(b_signed),
    .acc_sel(acc_sel), .op(op), .frac_en(frac_en), .sat_en(sat_en),
    .acc0(acc0), .acc1(acc1), .ovf(ovf)
  );

  function automatic longint ext16(logic [15:0] v, logic s);
    if (s) return longint'($signed(v));
    return longint'(v);
  endfunction

  function automatic longint wrap40(longint v);
    longint w;
    w = v & ((64'sd1 <<< 40) - 1);
    if (w > ACC_MAX) w = w - (64'sd1 <<< 40);
    return w;
  endfunction

  task automatic model(logic [1:0] o, logic s, logic [15:0] a, logic [15:0] b,
                       logic as, logic bs, logic fr, logic sat);
    longint p, sum;
    p = ext16(a, as) * ext16(b, bs);
    if (fr) p = p * 2;
    if (o == 2'd0) begin
      m_acc[s] = 0;
      m_ovf[s] = 1'b0;
    end else begin
      if (o == 2'd1)      sum = p;
      else if (o == 2'd2) sum = m_acc[s] + p;
      else                sum = m_acc[s] - p;
      if (sum > ACC_MAX || sum < ACC_MIN) m_ovf[s] = 1'b1;
      if (sat && sum > SAT_HI)      m_acc[s] = SAT_HI;
      else if (sat && sum < SAT_LO) m_acc[s] = SAT_LO;
      else                          m_acc[s] = wrap40(sum);
    end
  endtask

  task automatic compare(string req);
    longint g0, g1;
    g0 = $signed(acc0);
    g1 = $signed(acc1);
    n_vec++;
    if (g0 !== m_acc[0] || g1 !== m_acc[1] || ovf !== {m_ovf[1], m_ovf[0]}) begin
      n_bad++;
      $display("FAIL %s: acc0=%h acc1=%h ovf=%b expected acc0=%h acc1=%h ovf=%b",
               req, acc0, acc1, ovf, m_acc[0][39:0], m_acc[1][39:0], {m_ovf[1], m_ovf[0]});
    end
  endtask

  // Drive at a falling edge; result is due after the next rising edge and is
  // compared at the following falling edge.
  task automatic apply(string req, logic [1:0] o, logic s, logic [15:0] a, logic [15:0] b,
                       logic as, logic bs, logic fr, logic sat);
    in_valid = 1'b1; op = o; acc_sel = s; op_a = a; op_b = b;
    a_signed = as; b_signed = bs; frac_en = fr; sat_en = sat;
    model(o, s, a, b, as, bs, fr, sat);
    @(negedge clk);
    in_valid = 1'b0;
    compare(req);
  endtask

  task automatic idle(string req, logic [1:0] o, logic s);
    in_valid = 1'b0; op = o; acc_sel = s; op_a = 16'h7FFF; op_b = 16'h7FFF;
    a_signed = 1'b1; b_signed = 1'b1; frac_en = 1'b1; sat_en = 1'b0;
    @(negedge clk);
    compare(req);
  endtask

  function automatic logic [15:0] pick(int i);
    case (i)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'hFFFF; 3: return 16'h7FFF;
      4: return 16'h8000; 5: return 16'h1234; 6: return 16'hABCD; default: return 16'h0002;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_acc[0] = 0; m_acc[1] = 0; m_ovf[0] = 1'b0; m_ovf[1] = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    n_vec++;
    if (in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R12: in_ready=%b expected 1", in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R7: sweep of operand pairs, sign modes and fractional mode via load.
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 8; m++)
          apply("R2 R3 R7 product sweep", 2'd1, m[2], pick(i), pick(j), m[0], m[1], m[2], 1'b0);

    // R4: (-1.0) x (-1.0) in fractional mode.
    apply("R4 minus one squared", 2'd1, 1'b0, 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b0);
    n_vec++;
    if (acc0 !== 40'h0080000000) begin
      n_bad++;
      $display("FAIL R4: acc0=%h expected 0080000000", acc0);
    end

    // R5/R6: accumulate and subtract in both accumulators.
    apply("R8 clear", 2'd0, 1'b0, 0, 0, 0, 0, 0, 0);
    apply("R8 clear", 2'd0, 1'b1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 20; k++) begin
      apply("R5 multiply-add", 2'd2, k[0], 16'(k * 997), 16'(k * 313 + 5), k[1], k[2], k[3], 1'b0);
      apply("R6 multiply-subtract", 2'd3, k[0], 16'(k * 41), 16'h9001, 1'b1, k[1], k[2], 1'b0);
    end

    // R11: idle cycles with aggressive operands leave everything unchanged.
    idle("R11 idle no effect", 2'd2, 1'b0);
    idle("R11 idle no effect", 2'd0, 1'b1);

    // R9: saturation at both bounds.
    apply("R8 clear", 2'd0, 1'b0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++)
      apply("R9 saturate high", 2'd2, 1'b0, 16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b1);
    n_vec++;
    if (acc0 !== 40'h007FFFFFFF) begin
      n_bad++;
      $display("FAIL R9: acc0=%h expected 007FFFFFFF", acc0);
    end
    for (int k = 0; k < 8; k++)
      apply("R9 saturate low", 2'd3, 1'b0, 16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b1);
    n_vec++;
    if (acc0 !== 40'hFF80000000) begin
      n_bad++;
      $display("FAIL R9: acc0=%h expected FF80000000", acc0);
    end
    apply("R9 R4 minus one squared saturates", 2'd1, 1'b1, 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b1);

    // R10: wrap past 40 bits without saturation; sticky flag; cleared by R8.
    apply("R8 clear", 2'd0, 1'b1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 70; k++)
      apply("R10 wrap and sticky flag", 2'd2, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0);
    n_vec++;
    if (ovf[1] !== 1'b1) begin
      n_bad++;
      $display("FAIL R10: ovf[1]=%b expected 1", ovf[1]);
    end
    apply("R10 flag holds", 2'd1, 1'b1, 16'h0001, 16'h0001, 0, 0, 0, 0);
    apply("R8 clear drops flag", 2'd0, 1'b1, 0, 0, 0, 0, 0, 0);

    // Mixed random stream across all operations and both accumulators.
    void'($urandom(32'h5EED));
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0) idle("R11 random idle", r[5:4], r[6]);
      else apply("R5 R6 R9 R10 random stream", (r[7:4] == 4'd0) ? 2'd0 : r[9:8], r[10],
                 16'($urandom), 16'($urandom), r[11], r[12], r[13], r[14]);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule